// File: doc/BRIEF.md
# Page Access Rights Checker

This block decides, for a single memory access that has already hit a translation entry, which rights the access is granted and whether it faults. The inputs are the fields held in the matching entry and the current state of the requesting context. The entry supplies a rights type, two privilege bounds, an access identifier and three page status bits: dirty, break and reference-trap. The context supplies the current privilege level, the kind of access, a protection-check enable and a set of protection-identifier registers. The block is purely combinational, so its outputs follow its inputs within the same cycle.

The result is a three-bit rights mask and a fault indication with a code. The mask is bit 0 read, bit 1 write and bit 2 execute. The checks run in a fixed order. First the privilege bounds and the rights type build the base mask. Next the protection identifiers are compared. Then the requested right is tested against the mask. Last, the three status bits are applied, and each of them can strip rights and replace the fault found so far.

Entry lookup, miss handling and the registers that record a fault lie outside this block.

Top module: `pg_rights_chk`

## Requirements
- R1: Read is allowed by privilege when the current level is less than or equal to the entry's read bound (level 0 is the most privileged).
- R2: Write is allowed by privilege when the current level is less than or equal to the entry's write bound.
- R3: Execute is allowed by privilege only when the write bound is less than or equal to the current level and the current level is less than or equal to the read bound.
- R4: The rights type selects the base mask (bit 0 read, bit 1 write, bit 2 execute) from the privilege rights. Type 0 gives read, type 1 gives read and write, type 2 gives read and execute, type 3 gives all three, and types 4 to 7 give execute only.
- R5: When checking is enabled and the access id is nonzero, the value 2·id+1 is compared with every protection-id register. Any match clears the write bit of the mask.
- R6: A protection-id match on a write access (kind code 2) raises fault code 1, and the mask is returned with write cleared. No later check is made.
- R7: The kind code 0 (no access) never faults, and it returns the mask as it stands after R4 and R5.
- R8: A read (kind code 1), write (2) or execute (4) whose bit is absent from the mask faults. Execute raises code 2, and read or write raises code 3. The mask is returned unchanged.
- R9: When the dirty bit is clear, the write bit is cleared, and a write access raises code 4.
- R10: When the break bit is set, the write bit is cleared, and a write access raises code 5, which replaces code 4.
- R11: When the reference-trap bit is set, the mask is reduced to execute only, and any read or write raises code 6, which replaces codes 4 and 5.
- R12: The fault flag is high exactly when the fault code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pl_cur | input | PL_W | Current privilege level |
| acc_kind | input | 3 | Access kind: 0 none, 1 read, 2 write, 4 execute |
| prot_en | input | 1 | Protection-id check enable |
| ent_type | input | 3 | Entry rights type |
| ent_pl1 | input | PL_W | Entry read bound |
| ent_pl2 | input | PL_W | Entry write bound |
| ent_aid | input | ID_W | Entry access id (0 means public) |
| ent_d | input | 1 | Dirty bit |
| ent_b | input | 1 | Break bit |
| ent_t | input | 1 | Reference-trap bit |
| pid_regs | input | NPID*(ID_W+1) | Protection-id registers, register k in bits [k*(ID_W+1) +: ID_W+1] |
| rights | output | 3 | Granted mask: bit 0 read, bit 1 write, bit 2 execute |
| fault_vld | output | 1 | A fault is raised |
| fault_code | output | 3 | 0 none, 1 prot-id, 2 instr prot, 3 data rights, 4 dirty, 5 break, 6 reference |

## Verification
The directed vectors exercise the following cases:
- Privilege levels sit on each bound, one below it and one above it, which separates the inclusive comparisons from the strict ones.
- All eight type values appear under each access kind.
- Protection-id registers hold 2·id+1 and also 2·id, which shows that bit 0 takes part in the match.
- A public id of zero is presented together with a register that holds 1.
- The status bits are combined in pairs and all three together on write, read and execute, so that the override order can be observed.

A long pseudo-random sweep over small field ranges then mixes all of these cases. Each result is compared against a behavioural model that also reports which rule decided the outcome.

// File: rtl/pg_rights_chk.sv
module pg_rights_chk #(
  parameter int PL_W = 2,
  parameter int ID_W = 18,
  parameter int NPID = 4,
  localparam int PID_W = ID_W + 1
) (
  input  logic [PL_W-1:0]       pl_cur,
  input  logic [2:0]            acc_kind,
  input  logic                  prot_en,
  input  logic [2:0]            ent_type,
  input  logic [PL_W-1:0]       ent_pl1,
  input  logic [PL_W-1:0]       ent_pl2,
  input  logic [ID_W-1:0]       ent_aid,
  input  logic                  ent_d,
  input  logic                  ent_b,
  input  logic                  ent_t,
  input  logic [NPID*PID_W-1:0] pid_regs,
  output logic [2:0]            rights,
  output logic                  fault_vld,
  output logic [2:0]            fault_code
);
  localparam logic [2:0] K_NONE = 3'd0, K_WR = 3'd2;
  localparam logic [2:0] F_NONE = 3'd0, F_PID = 3'd1, F_IPROT = 3'd2,
                         F_DRIGHTS = 3'd3, F_DIRTY = 3'd4, F_BREAK = 3'd5,
                         F_REF = 3'd6;

  logic can_r, can_w, can_x;
  assign can_r = pl_cur <= ent_pl1;
  assign can_w = pl_cur <= ent_pl2;
  assign can_x = (ent_pl2 <= pl_cur) && (pl_cur <= ent_pl1);

  logic [2:0] base;
  always_comb begin
    case (ent_type)
      3'd0:    base = {2'b00, can_r};
      3'd1:    base = {1'b0, can_w, can_r};
      3'd2:    base = {can_x, 1'b0, can_r};
      3'd3:    base = {can_x, can_w, can_r};
      default: base = {can_x, 2'b00};
    endcase
  end

  logic [NPID-1:0] pid_hit;
  for (genvar g = 0; g < NPID; g++) begin : g_pid
    assign pid_hit[g] = pid_regs[g*PID_W +: PID_W] == {ent_aid, 1'b1};
  end

  logic pid_strip;
  assign pid_strip = prot_en && (|ent_aid) && (|pid_hit);

  logic [2:0] m, code;
  always_comb begin
    m    = base;
    code = F_NONE;
    if (pid_strip) m[1] = 1'b0;
    if (pid_strip && acc_kind == K_WR) begin
      code = F_PID;
    end else if (acc_kind == K_NONE) begin
      code = F_NONE;
    end else if ((m & acc_kind) == 3'b000) begin
      code = acc_kind[2] ? F_IPROT : F_DRIGHTS;
    end else begin
      if (!ent_d) begin
        m[1] = 1'b0;
        if (acc_kind[1]) code = F_DIRTY;
      end
      if (ent_b) begin
        m[1] = 1'b0;
        if (acc_kind[1]) code = F_BREAK;
      end
      if (ent_t) begin
        m[1:0] = 2'b00;
        if (!acc_kind[2]) code = F_REF;
      end
    end
  end

  assign rights     = m;
  assign fault_code = code;
  assign fault_vld  = code != F_NONE;
endmodule

// File: rtl/pg_rights_chk_sva.sv
module pg_rights_chk_sva #(
  parameter int PL_W = 2,
  parameter int ID_W = 18,
  parameter int NPID = 4,
  localparam int PID_W = ID_W + 1
) (
  input logic [PL_W-1:0]       pl_cur,
  input logic [2:0]            acc_kind,
  input logic                  prot_en,
  input logic [2:0]            ent_type,
  input logic [PL_W-1:0]       ent_pl1,
  input logic [PL_W-1:0]       ent_pl2,
  input logic [ID_W-1:0]       ent_aid,
  input logic                  ent_d,
  input logic                  ent_b,
  input logic                  ent_t,
  input logic [NPID*PID_W-1:0] pid_regs,
  input logic [2:0]            rights,
  input logic                  fault_vld,
  input logic [2:0]            fault_code
);
  always_comb begin
    p_read_bound_r1: assert (!rights[0] || pl_cur <= ent_pl1)
      else $error("read granted above read bound");
    p_write_bound_r2: assert (!rights[1] || pl_cur <= ent_pl2)
      else $error("write granted above write bound");
    p_exec_window_r3: assert (!rights[2] || (ent_pl2 <= pl_cur && pl_cur <= ent_pl1))
      else $error("execute granted outside window");
    p_pid_write_r6: assert (fault_code != 3'd1 || (acc_kind == 3'd2 && !rights[1]))
      else $error("prot-id fault on non-write or with write kept");
    p_none_quiet_r7: assert (acc_kind != 3'd0 || !fault_vld)
      else $error("fault on no-access probe");
    p_iprot_exec_r8: assert (fault_code != 3'd2 || acc_kind == 3'd4)
      else $error("instruction protection on non-execute");
    p_dirty_strip_r9: assert (ent_d || acc_kind == 3'd0 || fault_code inside {3'd1, 3'd2, 3'd3} || !rights[1])
      else $error("write kept with dirty clear");
    p_ref_mask_r11: assert (!ent_t || acc_kind == 3'd0 || fault_code inside {3'd1, 3'd2, 3'd3} || rights[1:0] == 2'b00)
      else $error("reference trap left read or write");
    p_flag_code_r12: assert (fault_vld == (fault_code != 3'd0) && fault_code <= 3'd6)
      else $error("fault flag and code disagree");
  end
endmodule

bind pg_rights_chk pg_rights_chk_sva #(.PL_W(PL_W), .ID_W(ID_W), .NPID(NPID)) u_sva (.*);

// File: tb/pg_rights_chk_bench.sv
`timescale 1ns/1ps
module pg_rights_chk_bench;
  localparam int PL_W = 2, ID_W = 18, NPID = 4, PID_W = ID_W + 1;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [PL_W-1:0]       pl_cur;
  logic [2:0]            acc_kind;
  logic                  prot_en;
  logic [2:0]            ent_type;
  logic [PL_W-1:0]       ent_pl1, ent_pl2;
  logic [ID_W-1:0]       ent_aid;
  logic                  ent_d, ent_b, ent_t;
  logic [NPID*PID_W-1:0] pid_regs;
  logic [2:0]            rights;
  logic                  fault_vld;
  logic [2:0]            fault_code;

  pg_rights_chk #(.PL_W(PL_W), .ID_W(ID_W), .NPID(NPID)) u_pg_rights_chk (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic model(output int m, output int code, output string tag);
    int pl, k, r, w, x;
    bit hit;
    pl = int'(pl_cur); k = int'(acc_kind);
    r = (pl <= int'(ent_pl1)) ? 1 : 0;
    w = (pl <= int'(ent_pl2)) ? 1 : 0;
    x = (int'(ent_pl2) <= pl && pl <= int'(ent_pl1)) ? 1 : 0;
    case (int'(ent_type))
      0: m = r;
      1: m = r + 2*w;
      2: m = r + 4*x;
      3: m = r + 2*w + 4*x;
      default: m = 4*x;
    endcase
    code = 0; tag = "R4";
    hit = 0;
    for (int i = 0; i < NPID; i++)
      if (prot_en && ent_aid != 0 &&
          longint'(pid_regs[i*PID_W +: PID_W]) == 2*longint'(ent_aid) + 1) hit = 1;
    if (hit) begin
      m = m & 5; tag = "R5";
      if (k == 2) begin code = 1; tag = "R6"; return; end
    end
    if (k == 0) begin tag = "R7"; return; end
    if ((m & k) == 0) begin code = (k == 4) ? 2 : 3; tag = "R8"; return; end
    if (!ent_d) begin m = m & 5; if (k == 2) begin code = 4; tag = "R9"; end end
    if (ent_b)  begin m = m & 5; if (k == 2) begin code = 5; tag = "R10"; end end
    if (ent_t)  begin m = m & 4; if (k != 4) begin code = 6; tag = "R11"; end end
  endtask

  task automatic check(input string note);
    int em, ec;
    string tag;
    model(em, ec, tag);
    n_chk++;
    if (int'(rights) != em || int'(fault_code) != ec) begin
      n_fail++;
      $display("FAIL %s (%s): rights=%0d code=%0d expected rights=%0d code=%0d",
               tag, note, rights, fault_code, em, ec);
    end
    n_chk++;
    if (fault_vld != (fault_code != 0)) begin
      n_fail++;
      $display("FAIL R12 (%s): fault_vld=%0b expected %0b", note, fault_vld, fault_code != 0);
    end
  endtask

  task automatic apply(input int pl, k, en, ty, p1, p2, aid, d, b, t, input string note);
    @(posedge clk); #1;
    pl_cur = pl[PL_W-1:0]; acc_kind = k[2:0]; prot_en = en[0]; ent_type = ty[2:0];
    ent_pl1 = p1[PL_W-1:0]; ent_pl2 = p2[PL_W-1:0]; ent_aid = aid[ID_W-1:0];
    ent_d = d[0]; ent_b = b[0]; ent_t = t[0];
    @(negedge clk);
    check(note);
  endtask

  task automatic set_pid(input int i, input int v);
    pid_regs[i*PID_W +: PID_W] = v[PID_W-1:0];
  endtask

  initial begin
    pl_cur = 0; acc_kind = 0; prot_en = 0; ent_type = 0; ent_pl1 = 0; ent_pl2 = 0;
    ent_aid = 0; ent_d = 0; ent_b = 0; ent_t = 0; pid_regs = '0;
    @(negedge clk);
    check("all-zero inputs R7");
    for (int pl = 0; pl < 4; pl++)
      for (int k = 0; k < 3; k++)
        apply(pl, (k == 0) ? 1 : (k == 1) ? 2 : 4, 0, 3, 2, 1, 0, 1, 0, 0, "bounds R1 R2 R3");
    for (int ty = 0; ty < 8; ty++)
      for (int k = 0; k < 4; k++)
        apply(1, (k == 3) ? 4 : k, 0, ty, 3, 0, 0, 1, 0, 0, "type table R4");
    set_pid(2, 2*5 + 1);
    apply(0, 2, 1, 1, 3, 3, 5, 1, 0, 0, "pid write R6");
    apply(0, 1, 1, 1, 3, 3, 5, 1, 0, 0, "pid read R5");
    apply(0, 0, 1, 3, 3, 3, 5, 1, 0, 0, "pid probe R7");
    apply(0, 2, 0, 1, 3, 3, 5, 1, 0, 0, "pid disabled R5");
    set_pid(2, 2*5);
    apply(0, 2, 1, 1, 3, 3, 5, 1, 0, 0, "pid bit0 clear R5");
    set_pid(0, 1);
    apply(0, 2, 1, 1, 3, 3, 0, 1, 0, 0, "public id R5");
    pid_regs = '0;
    apply(3, 1, 0, 1, 2, 2, 0, 1, 0, 0, "read denied R8");
    apply(0, 4, 0, 1, 3, 0, 0, 0, 1, 1, "exec denied R8");
    apply(0, 2, 0, 3, 3, 3, 0, 0, 0, 0, "dirty R9");
    apply(0, 2, 0, 3, 3, 3, 0, 0, 1, 0, "break over dirty R10");
    apply(0, 2, 0, 3, 3, 3, 0, 0, 1, 1, "ref over break R11");
    apply(0, 1, 0, 3, 3, 0, 0, 0, 1, 1, "ref on read R11");
    apply(0, 4, 0, 3, 3, 0, 0, 0, 1, 1, "exec with trap R11");
    for (int n = 0; n < 4000; n++) begin
      int aid;
      aid = int'($urandom_range(0, 3));
      for (int i = 0; i < NPID; i++)
        set_pid(i, int'($urandom_range(0, 8)));
      apply(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)) == 3 ? 4 : int'($urandom_range(0, 2)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), aid,
            int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
            "random sweep");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule